// File: doc/BRIEF.md
# Fractional-N Multi-Modulus Divider Controller

This block is the digital controller of a main divider in a fractional-N synthesizer. Its clock is the output of an external multi-modulus prescaler, so one clock is one prescaler period. A division cycle runs through up to four counting phases. In each phase the controller drives a two-bit modulus code to the prescaler and holds that code for a programmed number of periods. The prescaler type input selects which phases a cycle uses.

A fractional accumulator adds a 3-bit increment once per cycle. It wraps at 8 or at 5, depending on the modulus select. An overflow shortens the first-ratio phase of the next cycle by one period and lengthens the second-ratio phase by one period. With a second ratio one higher than the first, this raises that cycle's division by exactly one. The divider pulse marks the last period of every cycle. The accumulator contents go out for compensation.

Phase counts and prescaler type are sampled only when a cycle ends, so no cycle runs with a mix of old and new counts. The load-window output tells an upstream loader that the current cycle has reached its last phase.

Top module: `fracn_mod_ctrl`

## Requirements
- R1: The prescaler type selects the phase order within a cycle. 01 runs phases 1 and 2. 10 runs phases 1, 2 and 3. 11 runs phases 1, 2, 3 and 4. 00 runs phases 1, 2 and 4. Phases never appear out of ascending order, and a phase 2 of zero length is skipped.
- R2: The modulus code {fb1,fb2} is 10 in phase 1, 00 in phase 2, 01 in phase 3 and 11 in phase 4.
- R3: In a cycle without overflow the phase lengths in periods are m1+2, m2, m3+1 and m4+1.
- R4: In a cycle that follows an accumulator overflow, phase 1 lasts m1+1 periods and phase 2 lasts m2+1 periods.
- R5: m2 is used at its full 8 bits when the type is 01. For any other type only its low 4 bits are used.
- R6: div_pulse is high for exactly one period per cycle, the last one. The following period is in phase 1.
- R7: frd changes only at the edge that ends a cycle, where it takes (frd + increment) mod Q, or at a modulus-select change. It is stable at all other times.
- R8: Q is 8 when fmod=1 and 5 when fmod=0. A sum of Q or more overflows and wraps by subtracting Q.
- R9: When fmod=0, an increment of 5 to 7 counts as the increment minus 5.
- R10: A change of fmod clears the accumulator. No overflow is applied to the cycle that starts at that edge.
- R11: Phase counts and type that change in the middle of a cycle do not alter that cycle. They govern the next cycle.
- R12: load_win is high in exactly the periods of the cycle's last phase, and div_pulse is high only while load_win is high.
- R13: During reset fb1=1, fb2=0, div_pulse=0, load_win=0 and frd=0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Prescaler output clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| m1 | input | 12 | Phase 1 count |
| m2 | input | 8 | Phase 2 count (low 4 bits used unless type is 01) |
| m3 | input | 4 | Phase 3 count |
| m4 | input | 4 | Phase 4 count |
| ptype | input | 2 | Prescaler type, selects phase set |
| nf | input | 3 | Fractional increment |
| fmod | input | 1 | Accumulator modulus select (1: 8, 0: 5) |
| fb1 | output | 1 | Modulus control bit 1 |
| fb2 | output | 1 | Modulus control bit 2 |
| div_pulse | output | 1 | High in the last period of each cycle |
| load_win | output | 1 | High during the last phase of a cycle |
| frd | output | 3 | Accumulator contents |

## Verification
The hardest case to reach is an overflow that falls in a cycle with unusual phase lengths. Examples are a zero-length phase 2 that an overflow revives, or the first cycle after a modulus change, where the overflow is suppressed. The stimulus reaches these cases by repeating vectors with a chosen increment, so the accumulator walks to known overflow points. A reference model of the accumulator in the bench says which measured cycle must show the one-period swap. Inputs change only in the last period of a cycle, except in one test that changes them three periods into a cycle to show that the change waits for the boundary.

// File: rtl/fracn_mod_ctrl.sv
module fracn_mod_ctrl #(
  parameter int M1_W   = 12,
  parameter int M2_W   = 8,
  parameter int M2_NAR = 4,
  parameter int M34_W  = 4,
  parameter int ACC_W  = 3,
  parameter int Q_LO   = 5
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [M1_W-1:0]  m1,
  input  logic [M2_W-1:0]  m2,
  input  logic [M34_W-1:0] m3,
  input  logic [M34_W-1:0] m4,
  input  logic [1:0]       ptype,
  input  logic [ACC_W-1:0] nf,
  input  logic             fmod,
  output logic             fb1,
  output logic             fb2,
  output logic             div_pulse,
  output logic             load_win,
  output logic [ACC_W-1:0] frd
);

  localparam int CNT_W = M1_W + 1;
  localparam logic [ACC_W:0] QH = (ACC_W+1)'(1 << ACC_W);
  localparam logic [ACC_W:0] QL = (ACC_W+1)'(Q_LO);

  typedef enum logic [1:0] {PH1 = 2'd0, PH2 = 2'd1, PH3 = 2'd2, PH4 = 2'd3} ph_t;

  ph_t              ph, nxt;
  logic [CNT_W-1:0] cnt;
  logic             run, ovf, fmod_q;
  logic [M2_W-1:0]  w2;
  logic [M34_W-1:0] w3, w4;
  logic [1:0]       wpt;
  logic [ACC_W-1:0] acc;

  logic             use3, use4, skip2, is_final, last, boundary, fchg, ovf_new;
  logic [M2_W:0]    len2;
  logic [ACC_W-1:0] nf_eff;
  logic [ACC_W:0]   q, sum, wrapped;
  logic             sum_ovf;

  assign use3  = wpt[1];
  assign use4  = (wpt == 2'b11) || (wpt == 2'b00);
  assign len2  = {1'b0, w2} + (M2_W+1)'(ovf);
  assign skip2 = (len2 == '0);

  always_comb begin
    nxt      = PH1;
    is_final = 1'b0;
    case (ph)
      PH1: if (!skip2) nxt = PH2;
           else if (use3) nxt = PH3;
           else if (use4) nxt = PH4;
           else is_final = 1'b1;
      PH2: if (use3) nxt = PH3;
           else if (use4) nxt = PH4;
           else is_final = 1'b1;
      PH3: if (use4) nxt = PH4;
           else is_final = 1'b1;
      default: is_final = 1'b1;
    endcase
  end

  assign last      = run && is_final && (cnt == '0);
  assign boundary  = !run || last;
  assign div_pulse = last;
  assign load_win  = run && is_final;
  assign fb1       = ~(ph[1] ^ ph[0]);
  assign fb2       = ph[1];
  assign frd       = acc;

  assign nf_eff  = (!fmod && ({1'b0, nf} >= QL)) ? nf - QL[ACC_W-1:0] : nf;
  assign q       = fmod ? QH : QL;
  assign sum     = {1'b0, acc} + {1'b0, nf_eff};
  assign sum_ovf = (sum >= q);
  assign wrapped = sum_ovf ? sum - q : sum;
  assign fchg    = (fmod != fmod_q);
  assign ovf_new = run && !fchg && sum_ovf;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ph     <= PH1;
      cnt    <= '0;
      run    <= 1'b0;
      ovf    <= 1'b0;
      fmod_q <= 1'b0;
      w2     <= '0;
      w3     <= '0;
      w4     <= '0;
      wpt    <= 2'b01;
      acc    <= '0;
    end else begin
      fmod_q <= fmod;
      if (fchg)      acc <= '0;
      else if (last) acc <= wrapped[ACC_W-1:0];
      if (boundary) begin
        run <= 1'b1;
        ph  <= PH1;
        ovf <= ovf_new;
        w2  <= (ptype == 2'b01) ? m2 : M2_W'(m2[M2_NAR-1:0]);
        w3  <= m3;
        w4  <= m4;
        wpt <= ptype;
        cnt <= {1'b0, m1} + CNT_W'(!ovf_new);
      end else if (cnt != '0) begin
        cnt <= cnt - 1'b1;
      end else begin
        ph <= nxt;
        case (nxt)
          PH2:     cnt <= CNT_W'(len2) - 1'b1;
          PH3:     cnt <= CNT_W'(w3);
          default: cnt <= CNT_W'(w4);
        endcase
      end
    end
  end

endmodule

module fracn_mod_ctrl_chk #(
  parameter int ACC_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             fmod,
  input logic             fb1,
  input logic             fb2,
  input logic             div_pulse,
  input logic             load_win,
  input logic [ACC_W-1:0] frd
);
  AST_START_R1: assert property (@(posedge clk) disable iff (!rst_n) div_pulse |=> (fb1 && !fb2)); // R6
  AST_PULSE_IN_WIN: assert property (@(posedge clk) disable iff (!rst_n) div_pulse |-> load_win); // R12
  AST_MOD5_RANGE: assert property (@(posedge clk) disable iff (!rst_n) (!fmod && !$past(fmod)) |-> (frd < ACC_W'(5))); // R8
  AST_FRD_HOLD: assert property (@(posedge clk) disable iff (!rst_n) (!$past(div_pulse) && ($past(fmod) == $past(fmod, 2))) |-> $stable(frd)); // R7
endmodule

bind fracn_mod_ctrl fracn_mod_ctrl_chk #(.ACC_W(ACC_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .fmod(fmod), .fb1(fb1), .fb2(fb2),
  .div_pulse(div_pulse), .load_win(load_win), .frd(frd)
);

// File: tb/sim_fracn_mod_ctrl.sv
`timescale 1ns/1ps
module sim_fracn_mod_ctrl;
  logic clk = 0, rst_n = 0;
  logic [11:0] m1; logic [7:0] m2; logic [3:0] m3, m4;
  logic [1:0] ptype; logic [2:0] nf; logic fmod;
  logic fb1, fb2, div_pulse, load_win; logic [2:0] frd;
  int checks = 0, errors = 0;
  int acc_m = 0, ovf_m = 0; logic pf_m = 1;

  always #2 clk = ~clk;

  fracn_mod_ctrl u0 (.clk(clk), .rst_n(rst_n), .m1(m1), .m2(m2), .m3(m3), .m4(m4),
    .ptype(ptype), .nf(nf), .fmod(fmod), .fb1(fb1), .fb2(fb2),
    .div_pulse(div_pulse), .load_win(load_win), .frd(frd));

  typedef struct packed {
    logic [1:0] pt; logic [11:0] a; logic [7:0] b; logic [3:0] c; logic [3:0] d;
    logic [2:0] inc; logic fm;
  } vec_t;

  localparam int NV = 24;
  localparam vec_t VEC [NV] = '{
    '{2'b01, 12'd5, 8'd3, 4'd0, 4'd0, 3'd0, 1'b1},
    '{2'b01, 12'd3, 8'd0, 4'd0, 4'd0, 3'd0, 1'b1},
    '{2'b10, 12'd4, 8'd2, 4'd3, 4'd0, 3'd0, 1'b1},
    '{2'b11, 12'd2, 8'd5, 4'd1, 4'd2, 3'd0, 1'b1},
    '{2'b00, 12'd6, 8'd1, 4'd9, 4'd4, 3'd0, 1'b1},
    '{2'b01, 12'd2, 8'd31, 4'd0, 4'd0, 3'd0, 1'b1},
    '{2'b10, 12'd2, 8'd31, 4'd1, 4'd0, 3'd0, 1'b1},
    '{2'b11, 12'hFFF, 8'd255, 4'd15, 4'd15, 3'd0, 1'b1},
    '{2'b01, 12'd4, 8'd2, 4'd0, 4'd0, 3'd3, 1'b1},
    '{2'b01, 12'd4, 8'd2, 4'd0, 4'd0, 3'd3, 1'b1},
    '{2'b01, 12'd4, 8'd2, 4'd0, 4'd0, 3'd3, 1'b1},
    '{2'b01, 12'd4, 8'd2, 4'd0, 4'd0, 3'd3, 1'b1},
    '{2'b01, 12'd4, 8'd2, 4'd0, 4'd0, 3'd7, 1'b0},
    '{2'b01, 12'd4, 8'd2, 4'd0, 4'd0, 3'd7, 1'b0},
    '{2'b01, 12'd4, 8'd2, 4'd0, 4'd0, 3'd7, 1'b0},
    '{2'b01, 12'd4, 8'd2, 4'd0, 4'd0, 3'd7, 1'b0},
    '{2'b01, 12'd4, 8'd2, 4'd0, 4'd0, 3'd7, 1'b0},
    '{2'b01, 12'd4, 8'd2, 4'd0, 4'd0, 3'd7, 1'b0},
    '{2'b00, 12'd3, 8'd0, 4'd0, 4'd2, 3'd4, 1'b0},
    '{2'b00, 12'd3, 8'd0, 4'd0, 4'd2, 3'd4, 1'b0},
    '{2'b00, 12'd3, 8'd0, 4'd0, 4'd2, 3'd4, 1'b0},
    '{2'b10, 12'd0, 8'd0, 4'd0, 4'd0, 3'd5, 1'b1},
    '{2'b10, 12'd0, 8'd0, 4'd0, 4'd0, 3'd5, 1'b1},
    '{2'b10, 12'd0, 8'd0, 4'd0, 4'd0, 3'd5, 1'b1}
  };

  task automatic check(input bit ok, input string msg);
    checks++;
    if (!ok) begin errors++; $display("FAIL %s", msg); end
  endtask

  task automatic apply(input vec_t v);
    ptype = v.pt; m1 = v.a; m2 = v.b; m3 = v.c; m4 = v.d; nf = v.inc; fmod = v.fm;
  endtask

  task automatic model_step(input vec_t v);
    int q, ne, s;
    q = v.fm ? 8 : 5;
    ne = int'(v.inc);
    if (ne >= q) ne -= q;
    if (v.fm != pf_m) begin acc_m = 0; ovf_m = 0; end
    else begin
      s = acc_m + ne;
      ovf_m = (s >= q) ? 1 : 0;
      acc_m = ovf_m ? s - q : s;
    end
    pf_m = v.fm;
  endtask

  task automatic run_cycle(input vec_t v, input bit mid, input vec_t mv, input string tag);
    int c [4]; int e [4]; int lw, elw, n, idx, lastidx; bit ord;
    e[0] = int'(v.a) + 2 - ovf_m;
    e[1] = ((v.pt == 2'b01) ? int'(v.b) : int'(v.b[3:0])) + ovf_m;
    e[2] = v.pt[1] ? int'(v.c) + 1 : 0;
    e[3] = (v.pt == 2'b11 || v.pt == 2'b00) ? int'(v.d) + 1 : 0;
    elw = e[3] != 0 ? e[3] : e[2] != 0 ? e[2] : e[1] != 0 ? e[1] : e[0];
    foreach (c[k]) c[k] = 0;
    lw = 0; n = 0; lastidx = 0; ord = 1;
    forever begin
      @(negedge clk);
      n++;
      idx = ({fb1, fb2} == 2'b10) ? 0 : ({fb1, fb2} == 2'b00) ? 1 : ({fb1, fb2} == 2'b01) ? 2 : 3;
      if (idx < lastidx) ord = 0;
      lastidx = idx;
      c[idx]++;
      if (load_win) lw++;
      if (mid && n == 3) apply(mv);
      if (div_pulse) break;
    end
    check(c[0] == e[0] && c[1] == e[1] && c[2] == e[2] && c[3] == e[3],
      $sformatf("R1 R2 R3 R4 R5 R6 R11 %s phase lengths got %0d/%0d/%0d/%0d exp %0d/%0d/%0d/%0d",
        tag, c[0], c[1], c[2], c[3], e[0], e[1], e[2], e[3]));
    check(ord, $sformatf("R1 %s phase order got %0d exp 1", tag, ord));
    check(lw == elw, $sformatf("R12 %s load_win periods got %0d exp %0d", tag, lw, elw));
    check(int'(frd) == acc_m, $sformatf("R7 R8 R9 R10 %s frd got %0d exp %0d", tag, frd, acc_m));
  endtask

  initial begin
    #(150000 * 4);
    errors++;
    $display("FAIL watchdog expired");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    vec_t va, vb;
    apply(VEC[0]);
    repeat (3) @(negedge clk);
    check(fb1 == 1 && fb2 == 0 && div_pulse == 0 && load_win == 0 && frd == 0,
      $sformatf("R13 reset outputs got %b%b%b%b %0d exp 1000 0", fb1, fb2, div_pulse, load_win, frd));
    rst_n = 1;
    do @(negedge clk); while (!div_pulse);
    for (int i = 0; i < NV; i++) begin
      apply(VEC[i]);
      model_step(VEC[i]);
      run_cycle(VEC[i], 1'b0, VEC[i], $sformatf("vec%0d", i));
    end
    va = '{2'b01, 12'd5, 8'd3, 4'd0, 4'd0, 3'd0, 1'b1};
    vb = '{2'b11, 12'd2, 8'd2, 4'd2, 4'd2, 3'd0, 1'b1};
    apply(va);
    model_step(va);
    run_cycle(va, 1'b1, vb, "R11 mid-change old cycle");
    model_step(vb);
    run_cycle(vb, 1'b0, vb, "R11 mid-change next cycle");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule